// File: doc/BRIEF.md
# Four-Lane Code-Group Deskew

This block lines up four byte-wide lanes of decoded code-group data that arrive with different delays. Each lane carries a data byte and a control flag, comes from its own word aligner, and has its own sync status input. All four lanes share one clock. Each lane goes into a small FIFO. The FIFOs are then read out in lockstep, so that a common alignment code group leaves all four lanes in the same cycle.

A lane begins to store words only when it sees its first alignment code group. Reading is held back until every lane has started. Reading is then enabled for all four FIFOs in one cycle, as long as the last lane started no more than a bounded number of cycles after the first. After release, a monitor watches the columns of alignment code groups at the FIFO outputs. It raises a channel-aligned status after a run of aligned columns. It drops that status, and restarts the whole block, after a run of misaligned columns.

Top module: `deskew4_top`

## Requirements
- R1: The alignment code group is a word with the control flag set (`lane_k` = 1) and data byte 0x7C. A 0x7C byte with the control flag clear, or any other word, never starts a lane.
- R2: No lane starts unless `lane_sync` is high on all four lanes in the same cycle. An alignment code group seen while any sync bit is low is ignored.
- R3: From its first alignment code group on, a lane stores every word it receives, beginning with that code group. No FIFO is read, and `out_valid` stays low, until all four lanes have started.
- R4: If the last lane's first alignment code group arrives no more than 10 cycles after the earliest lane's, `out_valid` rises in the next cycle. In that first valid cycle every lane presents its alignment code group. After that, each lane presents its received words in order, one per cycle, so that the lanes are lined up.
- R5: If 10 cycles have passed since the earliest lane started and some lane still has not started, all pointers are cleared and the block waits for a new alignment code group on every lane. Read pointers are never released in this case.
- R6: Each lane FIFO holds 16 words. A FIFO never overflows or underflows, and the word order is kept when the skew is at its largest allowed value.
- R7: An aligned column is a cycle in which all four valid outputs present the alignment code group. `chan_aligned` rises in the cycle after the fourth aligned column since release, counting the first column at release plus three more.
- R8: A misaligned column is a valid cycle in which some lanes, but not all, present the alignment code group. While aligned, four misaligned columns with no aligned column between them drop `chan_aligned` and `out_valid` in the next cycle and restart the block. An aligned column resets that count.
- R9: If any `lane_sync` bit is low, then in the next cycle `out_valid` and `chan_aligned` are low and all pointers are cleared. A later restart presents the new first alignment code group on every lane.
- R10: While `out_valid` is low, `out_data` and `out_k` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all lanes |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_sync | input | 4 | Per-lane sync status from the word aligners |
| lane_data | input | 32 | Received data bytes, lane n in bits 8n+7..8n |
| lane_k | input | 4 | Per-lane control flag of the received word |
| out_data | output | 32 | Deskewed data bytes, lane n in bits 8n+7..8n |
| out_k | output | 4 | Deskewed per-lane control flag |
| out_valid | output | 1 | High while the read pointers are released |
| chan_aligned | output | 1 | Channel alignment acquired |

## Verification
The assertions assume that inputs change only between clock edges and that the skew window is shorter than the FIFO depth. Under that assumption, the occupancy of the earliest lane at release can never exceed its storage, which is what the overflow property relies on. The stimulus sends each lane a periodic stream with an alignment code group every 32 words. The delays between lanes always stay below that period, so a lane cannot lock onto a different column than its neighbours. To produce misaligned columns, the bench replaces chosen code groups on one lane with ordinary data.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_GATHER = 2'd1,
        PH_RUN    = 2'd2
    } phase_e;

endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [WORD_W-1:0]           wr_word,
    output logic [WORD_W-1:0]           rd_word,
    output logic [$clog2(DEPTH):0]      level
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [AW-1:0]                wptr;
        logic [AW-1:0]                rptr;
        logic [CW-1:0]                cnt;
    } fifo_s;

    fifo_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (wr_en) begin
                st_d.mem[st_q.wptr] = wr_word;
                st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
            end
            if (rd_en) begin
                st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(wr_en) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = st_q.mem[st_q.rptr];
    assign level   = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && !clr) |-> (st_q.cnt < CW'(DEPTH))); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !clr) |-> (st_q.cnt != '0)); // R6

endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int SKEW_WIN = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_sync,
    input  logic [LANES-1:0] lane_is_a,
    input  logic [LANES-1:0] lane_full,
    input  logic             lose,
    output logic [LANES-1:0] wr_en,
    output logic             rd_en,
    output logic             clr,
    output logic             run
);

    localparam int WW = $clog2(SKEW_WIN + 2);

    typedef struct packed {
        phase_e           phase;
        logic [LANES-1:0] started;
        logic [WW-1:0]    win;
    } ctrl_s;

    ctrl_s st_d, st_q;

    logic             sync_ok;
    logic [LANES-1:0] new_start;
    logic [LANES-1:0] now_started;

    always_comb begin
        sync_ok     = &lane_sync;
        new_start   = lane_is_a & ~st_q.started;
        now_started = st_q.started | new_start;
        st_d        = st_q;
        wr_en       = '0;
        rd_en       = 1'b0;
        clr         = 1'b0;

        if (!sync_ok || lose) begin
            st_d = '0;
            clr  = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_IDLE, PH_GATHER: begin
                    wr_en = now_started;
                    if (|(now_started & lane_full)) begin
                        st_d  = '0;
                        clr   = 1'b1;
                        wr_en = '0;
                    end else if (&now_started) begin
                        st_d.phase   = PH_RUN;
                        st_d.started = now_started;
                    end else if (st_q.phase == PH_GATHER && st_q.win >= WW'(SKEW_WIN)) begin
                        st_d  = '0;
                        clr   = 1'b1;
                        wr_en = '0;
                    end else begin
                        st_d.started = now_started;
                        if (|now_started) begin
                            st_d.phase = PH_GATHER;
                            st_d.win   = st_q.win + 1'b1;
                        end
                    end
                end
                PH_RUN: begin
                    wr_en = '1;
                    rd_en = 1'b1;
                end
                default: begin
                    st_d = '0;
                    clr  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = (st_q.phase == PH_RUN);

    AST_READ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (&st_q.started)); // R3

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_GATHER) |-> (st_q.win <= WW'(SKEW_WIN))); // R5

    AST_NO_WRITE_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync) |-> (wr_en == '0)); // R2

endmodule

// File: rtl/deskew_align_mon.sv
module deskew_align_mon #(
    parameter int LANES     = 4,
    parameter int ACQ_EXTRA = 3,
    parameter int LOSE_COLS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sync_ok,
    input  logic [LANES-1:0] out_is_a,
    output logic             aligned,
    output logic             lose
);

    localparam int AQW = $clog2(ACQ_EXTRA + 1);
    localparam int LSW = $clog2(LOSE_COLS + 1);

    typedef struct packed {
        logic           seen_first;
        logic [AQW-1:0] acq_cnt;
        logic           aligned;
        logic [LSW-1:0] mis_cnt;
    } mon_s;

    mon_s st_d, st_q;

    logic col_all;
    logic col_mis;

    always_comb begin
        col_all = run && (&out_is_a);
        col_mis = run && (|out_is_a) && !(&out_is_a);
        lose    = st_q.aligned && col_mis && (st_q.mis_cnt == LSW'(LOSE_COLS - 1));
        st_d    = st_q;

        if (!run || !sync_ok || lose) begin
            st_d = '0;
        end else if (!st_q.aligned) begin
            if (col_all) begin
                if (!st_q.seen_first) begin
                    st_d.seen_first = 1'b1;
                end else if (st_q.acq_cnt == AQW'(ACQ_EXTRA - 1)) begin
                    st_d.aligned = 1'b1;
                    st_d.acq_cnt = '0;
                    st_d.mis_cnt = '0;
                end else begin
                    st_d.acq_cnt = st_q.acq_cnt + 1'b1;
                end
            end
        end else begin
            if (col_all)      st_d.mis_cnt = '0;
            else if (col_mis) st_d.mis_cnt = st_q.mis_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aligned = st_q.aligned;

    AST_ACQ_ON_ALIGNED_COL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.aligned) |-> $past(col_all)); // R7

    AST_LOSE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        lose |=> !st_q.aligned); // R8

    AST_MIS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mis_cnt < LSW'(LOSE_COLS)); // R8

endmodule

// File: rtl/deskew4_top.sv
module deskew4_top
    import deskew_pkg::*;
#(
    parameter int                LANES      = 4,
    parameter int                DATA_W     = 8,
    parameter int                FIFO_DEPTH = 16,
    parameter int                SKEW_WIN   = 10,
    parameter int                ACQ_EXTRA  = 3,
    parameter int                LOSE_COLS  = 4,
    parameter logic [DATA_W-1:0] ALIGN_CODE = 8'h7C
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_sync,
    input  logic [LANES*DATA_W-1:0] lane_data,
    input  logic [LANES-1:0]        lane_k,
    output logic [LANES*DATA_W-1:0] out_data,
    output logic [LANES-1:0]        out_k,
    output logic                    out_valid,
    output logic                    chan_aligned
);

    localparam int WORD_W = DATA_W + 1;
    localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

    logic [LANES-1:0] in_is_a;
    logic [LANES-1:0] out_is_a;
    logic [LANES-1:0] lane_full;
    logic [LANES-1:0] wr_en;
    logic             rd_en;
    logic             clr;
    logic             run;
    logic             lose;
    logic             aligned;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] rd_word;
        logic [LVL_W-1:0]  lvl;

        assign in_is_a[g] = lane_k[g] && (lane_data[g*DATA_W +: DATA_W] == ALIGN_CODE);

        deskew_lane_fifo #(
            .WORD_W (WORD_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .wr_en   (wr_en[g]),
            .rd_en   (rd_en),
            .wr_word ({lane_k[g], lane_data[g*DATA_W +: DATA_W]}),
            .rd_word (rd_word),
            .level   (lvl)
        );

        assign lane_full[g] = (lvl == LVL_W'(FIFO_DEPTH));
        assign out_is_a[g]  = rd_word[DATA_W] && (rd_word[DATA_W-1:0] == ALIGN_CODE);
        assign out_k[g]     = run & rd_word[DATA_W];
        assign out_data[g*DATA_W +: DATA_W] = run ? rd_word[DATA_W-1:0] : '0;
    end

    deskew_ctrl #(
        .LANES    (LANES),
        .SKEW_WIN (SKEW_WIN)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_sync (lane_sync),
        .lane_is_a (in_is_a),
        .lane_full (lane_full),
        .lose      (lose),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .clr       (clr),
        .run       (run)
    );

    deskew_align_mon #(
        .LANES     (LANES),
        .ACQ_EXTRA (ACQ_EXTRA),
        .LOSE_COLS (LOSE_COLS)
    ) u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sync_ok  (&lane_sync),
        .out_is_a (out_is_a),
        .aligned  (aligned),
        .lose     (lose)
    );

    assign out_valid    = run;
    assign chan_aligned = aligned;

    AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0 && out_k == '0)); // R10

    AST_RELEASE_ALL_A: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (&out_is_a)); // R4

    AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_sync) |=> (!out_valid && !chan_aligned)); // R9

endmodule

// File: tb/tb_deskew4_top.sv
module tb_deskew4_top;

    localparam int PER = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  lane_sync;
    logic [31:0] lane_data;
    logic [3:0]  lane_k;
    logic [31:0] out_data;
    logic [3:0]  out_k;
    logic        out_valid;
    logic        chan_aligned;

    int tests = 0;
    int fails = 0;
    int skew[4];
    logic [31:0] corrupt_mask;
    bit plain_mode;

    always #10 clk = ~clk;

    deskew4_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_sync    (lane_sync),
        .lane_data    (lane_data),
        .lane_k       (lane_k),
        .out_data     (out_data),
        .out_k        (out_k),
        .out_valid    (out_valid),
        .chan_aligned (chan_aligned)
    );

    function automatic logic [8:0] word(int l, int n);
        if (n < 0) return {1'b1, 8'hBC};
        if (plain_mode) return {1'b0, 8'h7C};
        if ((n % PER) == 0 && !(l == 0 && (n / PER) < 32 && corrupt_mask[n / PER]))
            return {1'b1, 8'h7C};
        return {1'b0, 8'(n * 7 + 3)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_cycle(input int c);
        for (int l = 0; l < 4; l++) begin
            logic [8:0] w;
            w = word(l, c - skew[l]);
            lane_data[l*8 +: 8] = w[7:0];
            lane_k[l] = w[8];
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_lanes(input int n, input string req);
        for (int l = 0; l < 4; l++) begin
            logic [8:0] e;
            e = word(l, n);
            chk({out_k[l], out_data[l*8 +: 8]} == e, req, $sformatf("lane %0d word n=%0d", l, n),
                {23'd0, out_k[l], out_data[l*8 +: 8]}, {23'd0, e});
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        lane_sync = 4'h0;
        lane_data = '0;
        lane_k = '0;
        corrupt_mask = '0;
        plain_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        apply_reset();
        chk(out_valid == 1'b0, "R10", "valid after reset", {31'd0, out_valid}, 0);
        chk(chan_aligned == 1'b0, "R7", "aligned after reset", {31'd0, chan_aligned}, 0);
        chk(out_data == '0 && out_k == '0, "R10", "data after reset", out_data, 0);
    endtask

    task automatic t_r1_plain_code();
        bit seen = 1'b0;
        bit nz = 1'b0;
        apply_reset();
        plain_mode = 1'b1;
        skew = '{0, 0, 0, 0};
        lane_sync = 4'hF;
        for (int c = 0; c < 40; c++) begin
            drive_cycle(c);
            if (out_valid) seen = 1'b1;
            if (out_data != '0) nz = 1'b1;
        end
        chk(!seen, "R1", "valid with 0x7C lacking control flag", {31'd0, seen}, 0);
        chk(!nz, "R10", "data nonzero while invalid", {31'd0, nz}, 0);
    endtask

    task automatic t_r2_sync_gate();
        bit early = 1'b0;
        apply_reset();
        skew = '{0, 1, 2, 3};
        for (int c = 0; c <= 40; c++) begin
            lane_sync = (c < 20) ? 4'b1011 : 4'hF;
            drive_cycle(c);
            if (c < 35 && out_valid) early = 1'b1;
            if (c == 35) begin
                chk(out_valid == 1'b1, "R2", "valid after synced marker", {31'd0, out_valid}, 1);
                check_lanes(32, "R2");
            end
            if (c == 40) check_lanes(37, "R4");
        end
        chk(!early, "R2", "early valid while a lane unsynced", {31'd0, early}, 0);
    endtask

    task automatic t_r4_max_skew();
        apply_reset();
        skew = '{0, 3, 7, 10};
        lane_sync = 4'hF;
        for (int c = 0; c <= 60; c++) begin
            drive_cycle(c);
            if (c == 9) chk(out_valid == 1'b0, "R3", "read frozen before last lane", {31'd0, out_valid}, 0);
            if (c == 10) begin
                chk(out_valid == 1'b1, "R4", "release at skew 10", {31'd0, out_valid}, 1);
                check_lanes(0, "R4");
            end
            if (c > 10 && (c % 7) == 0) check_lanes(c - 10, "R6");
        end
    endtask

    task automatic t_r5_over_window();
        bit seen = 1'b0;
        apply_reset();
        skew = '{0, 2, 5, 11};
        lane_sync = 4'hF;
        for (int c = 0; c < 130; c++) begin
            drive_cycle(c);
            if (out_valid) seen = 1'b1;
        end
        chk(!seen, "R5", "release with skew 11", {31'd0, seen}, 0);
        chk(out_data == '0, "R10", "data while waiting", out_data, 0);
    endtask

    task automatic t_r7_r8_acq_lose();
        apply_reset();
        skew = '{1, 0, 3, 2};
        corrupt_mask = 32'h0000_0F70;
        lane_sync = 4'hF;
        for (int c = 0; c <= 3 + 11 * PER + 1; c++) begin
            int j;
            drive_cycle(c);
            j = c - 3;
            if (j == 3 * PER) chk(chan_aligned == 1'b0, "R7", "aligned before 4th column", {31'd0, chan_aligned}, 0);
            if (j == 3 * PER + 1) chk(chan_aligned == 1'b1, "R7", "aligned after 4th column", {31'd0, chan_aligned}, 1);
            if (j == 4 * PER) check_lanes(j, "R8");
            if (j == 10 * PER + 1) chk(chan_aligned == 1'b1, "R8", "aligned column resets count", {31'd0, chan_aligned}, 1);
            if (j == 11 * PER) chk(chan_aligned == 1'b1 && out_valid == 1'b1, "R8", "still aligned at 4th miss", {30'd0, chan_aligned, out_valid}, 3);
            if (j == 11 * PER + 1) chk(chan_aligned == 1'b0 && out_valid == 1'b0, "R8", "lost after 4 misses", {30'd0, chan_aligned, out_valid}, 0);
        end
    endtask

    task automatic t_r9_sync_drop();
        apply_reset();
        skew = '{0, 0, 0, 0};
        lane_sync = 4'hF;
        for (int c = 0; c <= 130; c++) begin
            lane_sync = (c == 101) ? 4'b1101 : 4'hF;
            drive_cycle(c);
            if (c == 100) chk(chan_aligned == 1'b1, "R9", "aligned before drop", {31'd0, chan_aligned}, 1);
            if (c == 101) chk(out_valid == 1'b0 && chan_aligned == 1'b0 && out_data == '0, "R9", "outputs after sync drop",
                              {30'd0, out_valid, chan_aligned}, 0);
            if (c == 127) chk(out_valid == 1'b0, "R9", "no valid before new marker", {31'd0, out_valid}, 0);
            if (c == 128) check_lanes(128, "R9");
            if (c == 130) check_lanes(130, "R9");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_r1_plain_code();
        t_r2_sync_gate();
        t_r4_max_skew();
        t_r5_over_window();
        t_r7_r8_acq_lose();
        t_r9_sync_drop();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule